// File: doc/BRIEF.md
# Overload Retry Sequencer

Each output channel of a dual supply carries one copy of this block. It watches the overload comparator of its channel and decides if the channel's power stage may drive. In retry mode, an overload switches the output off for a long cool-down window. The block then turns the output back on, with the current limit engaged, for a short trial window, and repeats the cycle until the overload has gone. In clamp mode the output is never switched off. The block only reports whether the clamp is active.

A status flag records the overload condition for the control registers. In retry mode the flag rises on the first overload. It falls only after a trial window in which no overload is seen. Both windows are counted in pulses of a slow timebase tick, 1 ms in the intended use, and their lengths are parameters. The defaults are 900 ticks off and 20 ticks on. Overload reports are ignored while the channel is disabled and during its soft-start.

Top module: `ocp_retry_seq`

## Requirements
- R1: While `chan_en` is low, and from reset, `out_en`, `ilim_act` and `ovl_flag` are all 0 one clock after the enable is sampled low.
- R2: From the cycle after `chan_en` is sampled high until `softstart_done` is sampled high, `out_en` is 1, `ilim_act` is 0 and `ovl_flag` is 0, even when `overload` is high. After that the channel is in normal operation with `out_en` at 1.
- R3: In retry mode (`static_mode` = 0), an overload sampled during normal operation makes `out_en` 0 and `ovl_flag` 1 one clock later.
- R4: The off window lasts exactly `TICKS_OFF` cycles in which `tick` is high. The clock after the last of them, the trial window starts, with `out_en` = 1 and `ilim_act` = 1.
- R5: An overload sampled in any cycle of the trial window returns the channel to a fresh, full off window one clock later. This includes the cycle that carries the window's last tick.
- R6: When `TICKS_ON` ticks of the trial window pass with no overload, the channel returns to normal operation one clock after the last tick, with `ovl_flag` = 0 and `ilim_act` = 0.
- R7: In clamp mode (`static_mode` = 1), `out_en` stays 1 while the channel is enabled. During normal operation `ovl_flag` and `ilim_act` both equal the value `overload` had one clock earlier.
- R8: Setting `static_mode` while the channel is in the off or trial window returns it to normal operation one clock later. `ovl_flag` then takes the sampled `overload`.
- R9: In retry mode `ovl_flag` stays 1 for the whole of every off and trial window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle timebase pulse (1 ms nominal) |
| chan_en | input | 1 | Channel enable |
| softstart_done | input | 1 | Soft-start of the channel has finished |
| static_mode | input | 1 | 1 = clamp mode, 0 = retry mode |
| overload | input | 1 | Overload comparator output |
| out_en | output | 1 | Power stage may drive |
| ilim_act | output | 1 | Current limit is engaged |
| ovl_flag | output | 1 | Overload status flag |

## Verification
A wrong state register shows up one clock later as a wrong mix of `out_en` and `ilim_act`. For example, an output left driving after an overload, or a trial window with no limit. A tick counter that is off by one moves the rise of `out_en` at the end of the off window by a whole tick period. This is seen at the first window boundary. A flag register that clears early or late shows up at the end of the trial window or at a mode switch. The bench therefore compares all three outputs on every clock and walks through each window boundary tick by tick.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_RUN   = 3'd2,
    ST_OFF   = 3'd3,
    ST_ON    = 3'd4
  } ocp_state_e;

  // Next state of the sequencer from the current state and sampled inputs.
  function automatic ocp_state_e ocp_next(input ocp_state_e cur,
                                          input logic en,
                                          input logic ss_done,
                                          input logic stat,
                                          input logic ovl,
                                          input logic expd);
    ocp_state_e n;
    n = cur;
    if (!en) begin
      n = ST_IDLE;
    end else begin
      case (cur)
        ST_IDLE:  n = ST_START;
        ST_START: if (ss_done) n = ST_RUN;
        ST_RUN:   if (!stat && ovl) n = ST_OFF;
        ST_OFF: begin
          if (stat)      n = ST_RUN;
          else if (expd) n = ST_ON;
        end
        ST_ON: begin
          if (stat)      n = ST_RUN;
          else if (ovl)  n = ST_OFF;
          else if (expd) n = ST_RUN;
        end
        default:  n = ST_IDLE;
      endcase
    end
    return n;
  endfunction

  // Window length in ticks for a given state.
  function automatic int unsigned ocp_window(input ocp_state_e cur,
                                             input int unsigned t_off,
                                             input int unsigned t_on);
    int unsigned w;
    case (cur)
      ST_OFF:  w = t_off;
      ST_ON:   w = t_on;
      default: w = 1;
    endcase
    return w;
  endfunction

  // True in states where the power stage drives.
  function automatic logic ocp_drives(input ocp_state_e cur);
    return (cur == ST_START) || (cur == ST_RUN) || (cur == ST_ON);
  endfunction

endpackage

// File: rtl/ocp_win_timer.sv
module ocp_win_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic          last_tick;

  assign last_tick = ((cnt_q + 1'b1) == limit);
  assign expired   = run && tick && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  cnt_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/ocp_seq_fsm.sv
module ocp_seq_fsm
  import ocp_pkg::*;
#(
  parameter int unsigned TICKS_OFF = 900,
  parameter int unsigned TICKS_ON  = 20,
  parameter int unsigned CW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          softstart_done,
  input  logic          static_mode,
  input  logic          overload,
  input  logic          win_expired,
  output ocp_state_e    st_q,
  output logic          win_run,
  output logic          win_restart,
  output logic [CW-1:0] win_limit,
  output logic          ev_trip,
  output logic          ev_pass,
  output logic          ev_follow,
  output logic          ev_clear
);

  ocp_state_e st_d;

  assign st_d        = ocp_next(st_q, chan_en, softstart_done, static_mode,
                                overload, win_expired);
  assign win_run     = (st_q == ST_OFF) || (st_q == ST_ON);
  assign win_restart = (st_d != st_q);
  assign win_limit   = CW'(ocp_window(st_q, TICKS_OFF, TICKS_ON));

  assign ev_clear  = !chan_en || (st_q == ST_IDLE) || (st_q == ST_START);
  assign ev_follow = chan_en && static_mode && !ev_clear;
  assign ev_trip   = chan_en && !static_mode && overload &&
                     ((st_q == ST_RUN) || (st_q == ST_ON));
  assign ev_pass   = chan_en && !static_mode && !overload &&
                     (st_q == ST_ON) && win_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (st_q == ST_IDLE));

  // R5
  retry_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !static_mode && overload && st_q == ST_ON) |=> (st_q == ST_OFF));

  // R8
  mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && static_mode && win_run) |=> (st_q == ST_RUN));

endmodule

// File: rtl/ocp_flag_reg.sv
module ocp_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic follow,
  input  logic trip,
  input  logic pass,
  input  logic overload,
  output logic flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (clear)  flag_q <= 1'b0;
    else if (follow) flag_q <= overload;
    else if (trip)   flag_q <= 1'b1;
    else if (pass)   flag_q <= 1'b0;
  end

  // R6
  pass_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && !clear && !follow) |=> !flag_q);

endmodule

// File: rtl/ocp_retry_seq.sv
module ocp_retry_seq
  import ocp_pkg::*;
#(
  parameter int unsigned TICKS_OFF = 900,
  parameter int unsigned TICKS_ON  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic chan_en,
  input  logic softstart_done,
  input  logic static_mode,
  input  logic overload,
  output logic out_en,
  output logic ilim_act,
  output logic ovl_flag
);

  localparam int unsigned WMAX = (TICKS_OFF > TICKS_ON) ? TICKS_OFF : TICKS_ON;
  localparam int unsigned CW   = $clog2(WMAX + 1);

  ocp_state_e    st_q;
  logic          win_run;
  logic          win_restart;
  logic          win_expired;
  logic [CW-1:0] win_limit;
  logic          ev_trip;
  logic          ev_pass;
  logic          ev_follow;
  logic          ev_clear;

  ocp_seq_fsm #(
    .TICKS_OFF (TICKS_OFF),
    .TICKS_ON  (TICKS_ON),
    .CW        (CW)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .chan_en        (chan_en),
    .softstart_done (softstart_done),
    .static_mode    (static_mode),
    .overload       (overload),
    .win_expired    (win_expired),
    .st_q           (st_q),
    .win_run        (win_run),
    .win_restart    (win_restart),
    .win_limit      (win_limit),
    .ev_trip        (ev_trip),
    .ev_pass        (ev_pass),
    .ev_follow      (ev_follow),
    .ev_clear       (ev_clear)
  );

  ocp_win_timer #(
    .CW (CW)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (win_run),
    .restart (win_restart),
    .tick    (tick),
    .limit   (win_limit),
    .expired (win_expired)
  );

  ocp_flag_reg u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ev_clear),
    .follow   (ev_follow),
    .trip     (ev_trip),
    .pass     (ev_pass),
    .overload (overload),
    .flag_q   (ovl_flag)
  );

  assign out_en   = ocp_drives(st_q);
  assign ilim_act = (st_q == ST_ON) || ((st_q == ST_RUN) && ovl_flag);

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!out_en && !ovl_flag && !ilim_act));

  // R2
  softstart_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START) |-> !ovl_flag);

  // R3
  trip_shuts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !static_mode && overload && st_q == ST_RUN) |=> (!out_en && ovl_flag));

  // R7
  clamp_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && static_mode) |=> out_en);

  // R9
  flag_in_windows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_OFF) || (st_q == ST_ON)) |-> ovl_flag);

endmodule

// File: tb/ocp_retry_seq_bench.sv
module ocp_retry_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int T_OFF = 5;
  localparam int T_ON  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, chan_en = 1'b0, softstart_done = 1'b0;
  logic static_mode = 1'b0, overload = 1'b0;
  logic out_en, ilim_act, ovl_flag;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  oe;
    logic  il;
    logic  fl;
    string req;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_retry_seq #(.TICKS_OFF(T_OFF), .TICKS_ON(T_ON)) u_ocp_retry_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en),
    .softstart_done(softstart_done), .static_mode(static_mode),
    .overload(overload), .out_en(out_en), .ilim_act(ilim_act),
    .ovl_flag(ovl_flag)
  );

  task automatic compare(input exp_t e);
    n_checks++;
    if (out_en !== e.oe || ilim_act !== e.il || ovl_flag !== e.fl) begin
      n_errors++;
      $display("FAIL %s: got oe=%b il=%b fl=%b expected oe=%b il=%b fl=%b at %0t",
               e.req, out_en, ilim_act, ovl_flag, e.oe, e.il, e.fl, $time);
    end
  endtask

  // Monitor: pops one expectation after every clock edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) compare(exp_q.pop_front());
  end

  // Driver: sets inputs for the coming edge and queues the expected outputs.
  task automatic cyc(input logic en, input logic ss, input logic st,
                     input logic ov, input logic tk,
                     input logic e_oe, input logic e_il, input logic e_fl,
                     input string req);
    exp_t e;
    @(negedge clk);
    chan_en = en; softstart_done = ss; static_mode = st;
    overload = ov; tick = tk;
    e.oe = e_oe; e.il = e_il; e.fl = e_fl; e.req = req;
    exp_q.push_back(e);
  endtask

  // Full off window in retry mode, ending in the trial window (R4, R9).
  task automatic off_window(input string req);
    for (int i = 0; i < T_OFF; i++) begin
      cyc(1, 1, 0, 0, 0, 0, 0, 1, req);
      if (i == T_OFF - 1) cyc(1, 1, 0, 0, 1, 1, 1, 1, req);
      else                cyc(1, 1, 0, 0, 1, 0, 0, 1, req);
    end
  endtask

  // Clean trial window, ending in normal operation (R6).
  task automatic clean_on_window();
    for (int i = 0; i < T_ON; i++) begin
      cyc(1, 1, 0, 0, 0, 1, 1, 1, "R9 trial window");
      if (i == T_ON - 1) cyc(1, 1, 0, 0, 1, 1, 0, 0, "R6 clean trial clears flag");
      else               cyc(1, 1, 0, 0, 1, 1, 1, 1, "R9 trial window");
    end
  endtask

  task automatic bring_up();
    cyc(1, 0, 0, 0, 0, 1, 0, 0, "R2 soft-start entry");
    cyc(1, 1, 0, 0, 0, 1, 0, 0, "R2 normal after soft-start");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD * 2 + 2);
    n_checks++;
    if (out_en !== 1'b0 || ilim_act !== 1'b0 || ovl_flag !== 1'b0) begin
      n_errors++;
      $display("FAIL R1 reset: got oe=%b il=%b fl=%b expected 000", out_en, ilim_act, ovl_flag);
    end
    @(negedge clk); rst_n = 1'b1;

    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R1 disabled ignores overload");
    // R2 soft-start ignores overload
    cyc(1, 0, 0, 1, 0, 1, 0, 0, "R2 soft-start entry");
    cyc(1, 0, 0, 1, 1, 1, 0, 0, "R2 overload ignored in soft-start");
    cyc(1, 1, 0, 0, 0, 1, 0, 0, "R2 normal after soft-start");
    cyc(1, 1, 0, 0, 1, 1, 0, 0, "R2 normal steady");

    // R3 trip, R4 off window, R6 clean trial
    cyc(1, 1, 0, 1, 0, 0, 0, 1, "R3 overload trips");
    off_window("R4 off window");
    clean_on_window();

    // R5 overload mid trial
    cyc(1, 1, 0, 1, 0, 0, 0, 1, "R3 overload trips");
    off_window("R4 off window second");
    cyc(1, 1, 0, 0, 1, 1, 1, 1, "R9 trial window");
    cyc(1, 1, 0, 1, 0, 0, 0, 1, "R5 overload in trial");
    off_window("R5 fresh off window");
    // R5 overload on the last tick of the trial
    for (int i = 0; i < T_ON - 1; i++) cyc(1, 1, 0, 0, 1, 1, 1, 1, "R9 trial window");
    cyc(1, 1, 0, 1, 1, 0, 0, 1, "R5 overload on last tick");
    off_window("R5 fresh off window after last tick");
    clean_on_window();

    // R7 clamp mode
    cyc(1, 1, 1, 1, 0, 1, 1, 1, "R7 clamp flag follows");
    cyc(1, 1, 1, 1, 1, 1, 1, 1, "R7 clamp never off");
    cyc(1, 1, 1, 0, 0, 1, 0, 0, "R7 clamp flag clears");
    cyc(1, 1, 1, 0, 1, 1, 0, 0, "R7 clamp idle");

    // R8 mode switch during off window
    cyc(1, 1, 0, 1, 0, 0, 0, 1, "R3 overload trips");
    cyc(1, 1, 0, 0, 1, 0, 0, 1, "R9 off window");
    cyc(1, 1, 1, 0, 0, 1, 0, 0, "R8 switch in off window");
    // R8 mode switch during trial with overload present
    cyc(1, 1, 0, 1, 0, 0, 0, 1, "R3 overload trips");
    off_window("R4 off window before switch");
    cyc(1, 1, 1, 1, 0, 1, 1, 1, "R8 switch in trial follows overload");
    cyc(1, 1, 1, 0, 0, 1, 0, 0, "R8 then follows clear");

    // R1 disable mid off window, then restart
    cyc(1, 1, 0, 1, 0, 0, 0, 1, "R3 overload trips");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, "R1 disable clears flag");
    cyc(0, 1, 0, 0, 1, 0, 0, 0, "R1 disabled");
    bring_up();
    cyc(1, 1, 0, 1, 0, 0, 0, 1, "R3 trip after re-enable");
    off_window("R4 full off window after re-enable");
    clean_on_window();

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule